// File: doc/BRIEF.md
# Programmable Logic Liveness Monitor

This peripheral lets a host processor tell whether the programmable logic has been reconfigured or reset without the host asking for it, and whether that logic still reacts to it. It holds a sticky "fresh start" flag. The flag comes up set after configuration or after the logic's reset, and only a host write clears it. If software later finds the flag set again, the logic has restarted underneath it.

The host also drives a heartbeat pulse line into the block. The block brings the pulse into its own clock, detects each rising edge, and flips an echo bit once per pulse. Software reads the echo between heartbeats to confirm that the logic is responding. A constant version word identifies the loaded design. All registers sit behind a 32-bit AXI4-Lite slave.

Top module: `pl_live_mon`

## Requirements
- R1: After configuration or reset, a read of offset 0x0 returns 0x00000001. Bit 0 is the sticky flag and every other bit reads 0.
- R2: A write to offset 0x4 with wdata bit 0 = 1 and wstrb bit 0 = 1 clears the flag to 0. A write there with wdata bit 0 = 0, or with wstrb bit 0 = 0, leaves the flag unchanged.
- R3: Once cleared, the flag stays 0 through any bus traffic and heartbeat activity. Only rst sets it back to 1.
- R4: The echo bit resets to 0, both on the hb_echo output and in bit 0 of offset 0x8.
- R5: Each rising edge of hb_pulse inverts the echo bit exactly once, whatever the pulse width. The echo changes on the third rising clk edge after the pulse is first sampled high. Offset 0x8 reads the echo in bit 0 with all other bits 0.
- R6: A read of offset 0xC returns the VERSION parameter (default 0xA17E0001).
- R7: Reads of offsets that hold no readable register (0x4, and 0x10 upward) return 0. Every read and write response is OKAY (2'b00).
- R8: Writes to offsets 0x0, 0x8, 0xC and to unmapped offsets are accepted with an OKAY response and change no register.
- R9: The slave accepts a write address and its data in the same cycle and gives exactly one write response per write. bvalid is held until bready. rvalid and rdata are held stable until rready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_pulse | input | 1 | Heartbeat from the host side, asynchronous |
| hb_echo | output | 1 | Echo bit, inverted once per heartbeat |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The handshake assertions assume a well-behaved AXI4-Lite master. It holds each valid until the matching ready and presents the write address and data together. The bench tasks only ever drive the bus that way, and they add random delays before bready and rready. The echo assertion treats each synchronised rising edge as one event. The stimulus therefore keeps hb_pulse low for several clocks between pulses, so two heartbeats never merge into one. Pulse widths vary from one cycle up to many, to show that a long pulse still flips the echo only once.

// File: rtl/pl_live_pkg.sv
package pl_live_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [2:0] {
        SEL_FLAG,
        SEL_CLEAR,
        SEL_ECHO,
        SEL_VERSION,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic fresh;
        logic echo;
    } live_state_t;

    // Word-granular decode of a zero-extended byte address
    function automatic reg_sel_e decode_addr(input logic [31:0] byte_addr);
        case (byte_addr[31:2])
            30'd0:   return SEL_FLAG;
            30'd1:   return SEL_CLEAR;
            30'd2:   return SEL_ECHO;
            30'd3:   return SEL_VERSION;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pl_live_fresh_flag.sv
module pl_live_fresh_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic fresh
);
    // Declaration value gives the state at configuration; reset restores it
    logic fresh_q = 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            fresh_q <= 1'b1;
        else if (clr)
            fresh_q <= 1'b0;
    end

    assign fresh = fresh_q;
endmodule

// File: rtl/pl_live_hb_echo.sv
module pl_live_hb_echo #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hb_in,
    output logic rise,
    output logic echo
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         prev_q;
    logic         echo_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[TOP-1:0], hb_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= hb_in;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            echo_q <= 1'b0;
        end else begin
            prev_q <= sync_q[TOP];
            echo_q <= echo_q ^ rise;
        end
    end

    assign rise = sync_q[TOP] & ~prev_q;
    assign echo = echo_q;
endmodule

// File: rtl/pl_live_axil.sv
module pl_live_axil
    import pl_live_pkg::*;
#(
    parameter int              ADDR_W  = 6,
    parameter logic [DATA_W-1:0] VERSION = 32'hA17E_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  live_state_t       state,
    output logic              clr
);
    logic wr_fire;
    logic rd_fire;
    logic bvalid_q;
    logic rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    function automatic logic [DATA_W-1:0] read_word(input reg_sel_e sel, input live_state_t st);
        case (sel)
            SEL_FLAG:    return {{(DATA_W-1){1'b0}}, st.fresh};
            SEL_ECHO:    return {{(DATA_W-1){1'b0}}, st.echo};
            SEL_VERSION: return VERSION;
            default:     return '0;
        endcase
    endfunction

    assign wr_fire = awvalid & wvalid & ~bvalid_q;
    assign rd_fire = arvalid & ~rvalid_q;

    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign arready = ~rvalid_q;

    assign clr = wr_fire && (decode_addr(32'(awaddr)) == SEL_CLEAR)
                 && wstrb[0] && wdata[0];

    always_ff @(posedge clk) begin
        if (rst)
            bvalid_q <= 1'b0;
        else if (wr_fire)
            bvalid_q <= 1'b1;
        else if (bready)
            bvalid_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= read_word(decode_addr(32'(araddr)), state);
        end else if (rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign bvalid = bvalid_q;
    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;
    assign bresp  = RESP_OKAY;
    assign rresp  = RESP_OKAY;
endmodule

// File: rtl/pl_live_mon.sv
module pl_live_mon
    import pl_live_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] VERSION     = 32'hA17E_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hb_pulse,
    output logic              hb_echo,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);
    logic        fresh_w;
    logic        echo_w;
    logic        rise_w;
    logic        clr_w;
    live_state_t state_w;

    pl_live_fresh_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_w),
        .fresh (fresh_w)
    );

    pl_live_hb_echo #(.SYNC_STAGES(SYNC_STAGES)) u_hb (
        .clk   (clk),
        .rst   (rst),
        .hb_in (hb_pulse),
        .rise  (rise_w),
        .echo  (echo_w)
    );

    assign state_w.fresh = fresh_w;
    assign state_w.echo  = echo_w;

    pl_live_axil #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_bus (
        .clk     (clk),
        .rst     (rst),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .state   (state_w),
        .clr     (clr_w)
    );

    assign hb_echo = echo_w;
endmodule

// File: rtl/pl_live_mon_chk.sv
module pl_live_mon_chk (
    input logic        clk,
    input logic        rst,
    input logic        fresh,
    input logic        clr,
    input logic        rise,
    input logic        echo,
    input logic        awready,
    input logic        bvalid,
    input logic        bready,
    input logic [1:0]  bresp,
    input logic        rvalid,
    input logic        rready,
    input logic [1:0]  rresp,
    input logic [31:0] rdata
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !fresh |=> !fresh); // R3

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !fresh); // R2

    AST_ECHO_FLIPS: assert property (@(posedge clk) disable iff (rst)
        rise |=> (echo != $past(echo))); // R5

    AST_ECHO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(echo)); // R5

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid); // R9

    AST_ONE_RESP: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> !awready); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R9

    AST_RESP_OKAY: assert property (@(posedge clk) disable iff (rst)
        (bvalid || rvalid) |-> (bresp == 2'b00 && rresp == 2'b00)); // R7
endmodule

bind pl_live_mon pl_live_mon_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .fresh   (fresh_w),
    .clr     (clr_w),
    .rise    (rise_w),
    .echo    (echo_w),
    .awready (s_awready),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .bresp   (s_bresp),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .rresp   (s_rresp),
    .rdata   (s_rdata)
);

// File: tb/pl_live_mon_test.sv
`timescale 1ns/1ps
module pl_live_mon_test;
    localparam int          ADDR_W = 6;
    localparam logic [31:0] VER    = 32'hA17E_0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hb_pulse = 1'b0;
    logic hb_echo;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic s_awvalid = 1'b0;
    logic s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0] s_wstrb = '0;
    logic s_wvalid = 1'b0;
    logic s_wready;
    logic [1:0] s_bresp;
    logic s_bvalid;
    logic s_bready = 1'b0;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic s_arvalid = 1'b0;
    logic s_arready;
    logic [31:0] s_rdata;
    logic [1:0] s_rresp;
    logic s_rvalid;
    logic s_rready = 1'b0;

    int compared = 0;
    int mismatched = 0;
    logic mflag = 1'b1;
    logic mtog = 1'b0;

    always #10 clk = ~clk;

    pl_live_mon #(.ADDR_W(ADDR_W), .VERSION(VER)) uut (
        .clk(clk), .rst(rst), .hb_pulse(hb_pulse), .hb_echo(hb_echo),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
        case (a[ADDR_W-1:2])
            0:       return {31'b0, mflag};
            2:       return {31'b0, mtog};
            3:       return VER;
            default: return 32'h0;
        endcase
    endfunction

    task automatic axi_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic [3:0] strb, input string req);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = strb;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        #1;
        while (!(s_awready && s_wready)) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        check({req, " bvalid"}, {31'b0, s_bvalid}, 32'd1);
        check({req, " bresp"}, {30'b0, s_bresp}, 32'd0);
        repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            if (!s_bvalid) check("R9 bvalid held", 32'd0, 32'd1);
        end
        s_bready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_bready = 1'b0;
        check("R9 single response", {31'b0, s_bvalid}, 32'd0);
        if (a[ADDR_W-1:2] == 1 && strb[0] && d[0]) mflag = 1'b0;
    endtask

    task automatic axi_read(input logic [ADDR_W-1:0] a, input string req);
        logic [31:0] got;
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        got = s_rdata;
        check({req, " rresp"}, {30'b0, s_rresp}, 32'd0);
        check(req, got, exp_read(a));
        repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            if (!s_rvalid || s_rdata !== got) check("R9 rdata held", s_rdata, got);
        end
        s_rready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic heartbeat(input int width);
        @(negedge clk);
        hb_pulse = 1'b1;
        repeat (width) @(negedge clk);
        hb_pulse = 1'b0;
        repeat (5) @(negedge clk);
        mtog = ~mtog;
        check("R5 hb_echo port", {31'b0, hb_echo}, {31'b0, mtog});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mflag = 1'b1;
        mtog = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state
        axi_read(6'h00, "R1 flag after reset");
        axi_read(6'h08, "R4 echo after reset");
        check("R4 hb_echo port after reset", {31'b0, hb_echo}, 32'd0);
        axi_read(6'h0C, "R6 version");
        axi_read(6'h04, "R7 clear offset reads zero");
        axi_read(6'h10, "R7 unmapped read");
        axi_read(6'h3C, "R7 unmapped high read");

        // Clear attempts that must not take effect
        axi_write(6'h04, 32'hFFFF_FFFE, 4'hF, "R2 data bit0 zero");
        axi_read(6'h00, "R2 flag still set");
        axi_write(6'h04, 32'h0000_0001, 4'hE, "R2 strobe bit0 zero");
        axi_read(6'h00, "R2 flag still set after masked strobe");

        // Writes to read-only and unmapped offsets
        axi_write(6'h00, 32'h0, 4'hF, "R8 write flag offset");
        axi_write(6'h08, 32'h1, 4'hF, "R8 write echo offset");
        axi_write(6'h0C, 32'h0, 4'hF, "R8 write version offset");
        axi_write(6'h20, 32'h1, 4'hF, "R8 write unmapped");
        axi_read(6'h00, "R8 flag unchanged");
        axi_read(6'h08, "R8 echo unchanged");
        axi_read(6'h0C, "R8 version unchanged");

        // Clear
        axi_write(6'h04, 32'h1, 4'h1, "R2 clear");
        axi_read(6'h00, "R2 flag cleared");

        // Heartbeats: short and long pulses
        heartbeat(1);
        axi_read(6'h08, "R5 echo after one-cycle pulse");
        heartbeat(12);
        axi_read(6'h08, "R5 echo after long pulse");
        heartbeat(3);
        axi_read(6'h08, "R5 echo after third pulse");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            logic [ADDR_W-1:0] a;
            op = $urandom_range(0, 2);
            a = ADDR_W'($urandom_range(0, 15) << 2);
            case (op)
                0: heartbeat($urandom_range(1, 8));
                1: axi_read(a, "R3 random read");
                default: axi_write(a, $urandom, 4'($urandom), "R8 random write");
            endcase
        end
        axi_read(6'h00, "R3 flag after random traffic");
        axi_read(6'h08, "R5 echo after random traffic");

        // Reset brings the flag back and clears the echo
        axi_write(6'h04, 32'h1, 4'hF, "R2 clear before reset");
        if (!mtog) heartbeat(2);
        do_reset();
        axi_read(6'h00, "R3 flag set again by reset");
        axi_read(6'h08, "R4 echo zero after reset");
        check("R4 hb_echo port after second reset", {31'b0, hb_echo}, 32'd0);

        report();
    end
endmodule